// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a down-counting watchdog. A 12-bit counter steps down by one on every clock cycle in which the tick input is high. When it runs out, the block raises a one-cycle reset request, records the event in a sticky status bit and restarts itself from a programmable restart value. Software keeps the request from firing by restarting the counter in time, through a write to the control register.

A restart is accepted only when the same write carries a 16-bit unlock key in the upper half of the data word and sets the restart bit. A stray write with any other key, or with the restart bit clear, leaves the counter untouched. Register access uses a plain synchronous bus with byte offsets. Read data is registered and appears the cycle after the read strobe. The protection and clock-select slots are placeholders that read as zero.

Top module: `wdog_keyed_top`

## Requirements
- R1: After reset the counter holds 0xFFF, the restart register (offset 0x04) reads 0xFFF, the auxiliary mode register (offset 0x08) reads 0x7FFF, the status register (offset 0x0C) reads 0 and rst_req_o is low.
- R2: The counter decreases by exactly one in each cycle where tick_i is high, and it holds its value in every cycle where tick_i is low and no restart is accepted.
- R3: A cycle with tick_i high while the counter is 0 is an expiry. In the next cycle rst_req_o is high for one clock, status bit 0 is set, and the counter is reloaded from the restart register. With a restart value of N, an expiry therefore occurs on every (N+1)-th tick, and N = 0 expires on every tick.
- R4: A write to offset 0x00 whose data bits [31:16] equal 0x5FA0 and whose bit 0 is 1 loads the counter with the restart register value on the next clock.
- R5: A write to offset 0x00 with any other value in bits [31:16] has no effect, even when bit 0 is 1. A write with the correct key and bit 0 at 0 also has no effect.
- R6: Reads of offset 0x00, of 0x10 and 0x18, and of every unmapped offset return 0. Writes to those placeholder and unmapped offsets change nothing.
- R7: The restart register stores write data bits [11:0], and the mode register stores bits [14:0]. Higher bits read as 0. Writing the restart register does not reload the counter.
- R8: Reading the status register returns its value and clears bit 0. An expiry in the same cycle as that read leaves the bit set.
- R9: When an accepted restart and an expiry occur in the same cycle, the restart wins. The counter takes the restart value, no reset request is issued and the status bit is not set.
- R10: Read data for a read strobe in one cycle is presented on bus_rdata_o in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The assertions take it for granted that a write and a read never occur in the same cycle, and that the bus inputs are held low while reset is active. The $past-based checks on the counter depend on this, because they assume that nothing other than the tick or a keyed write moves it. The stimulus issues exactly one bus operation per cycle and keeps every strobe low during reset. Restart value changes are made only while no expiry is pending, so each counter step follows from the most recent tick or keyed write alone.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam logic [15:0] UNLOCK_KEY = 16'h5FA0;
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_RELOAD = 'h04;
  localparam int unsigned OFS_MODE1  = 'h08;
  localparam int unsigned OFS_STAT   = 'h0C;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             hit_o,
  output logic             rst_req_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  // expiry only when no accepted restart competes (restart wins)
  assign hit_o   = tick_i && (cnt_q == '0) && !kick_i;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q     <= '1;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= hit_o;
      if (kick_i)
        cnt_q <= reload_i;
      else if (tick_i) begin
        if (cnt_q == '0) cnt_q <= reload_i;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_kick_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> count_o == $past(reload_i));
  assert_step_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !kick_i && count_o != '0) |=> count_o == CNT_W'($past(count_o) - 1'b1));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !kick_i) |=> $stable(count_o));
  assert_expiry_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_o == '0 && !kick_i) |=> rst_req_o);
  assert_kick_no_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !rst_req_o);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned AUX_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hit_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_MODE1  = ADDR_W'(OFS_MODE1);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);

  logic [CNT_W-1:0]  reload_q;
  logic [AUX_W-1:0]  aux_q;
  logic              stat_q;
  logic [DATA_W-1:0] rmux;
  logic              unused_wbits;

  assign unused_wbits = ^wdata_i;
  assign kick_o   = we_i && (addr_i == A_CTRL)
                 && (wdata_i[DATA_W-1 -: 16] == UNLOCK_KEY) && wdata_i[0];
  assign reload_o = reload_q;

  always_comb begin
    rmux = '0;
    unique case (addr_i)
      A_RELOAD: rmux[CNT_W-1:0] = reload_q;
      A_MODE1:  rmux[AUX_W-1:0] = aux_q;
      A_STAT:   rmux[0]         = stat_q;
      default:  rmux            = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reload_q <= '1;
      aux_q    <= '1;
      stat_q   <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (we_i && addr_i == A_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
      if (we_i && addr_i == A_MODE1)  aux_q    <= wdata_i[AUX_W-1:0];
      if (hit_i)                            stat_q <= 1'b1;
      else if (re_i && addr_i == A_STAT)    stat_q <= 1'b0;
      rdata_o <= re_i ? rmux : '0;
    end
  end

  assert_stat_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> stat_q);
  assert_stat_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == A_STAT && !hit_i) |=> !stat_q);
  assert_ctrl_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == A_CTRL) |=> rdata_o == '0);
endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned AUX_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             kick;
  logic             hit;

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .AUX_W(AUX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .re_i    (bus_re_i),
    .wdata_i (bus_wdata_i),
    .hit_i   (hit),
    .reload_o(reload),
    .kick_o  (kick),
    .rdata_o (bus_rdata_o)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .kick_i   (kick),
    .reload_i (reload),
    .hit_o    (hit),
    .rst_req_o(rst_req_o),
    .count_o  (count)
  );

  // a badly keyed control write with no tick must leave the counter alone
  assert_badkey_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(OFS_CTRL) && !tick_i
     && bus_wdata_i[31:16] != UNLOCK_KEY) |=> $stable(count));
endmodule

// File: tb/test_wdog_keyed_top.sv
module test_wdog_keyed_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;
  bit rd_flag = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  wdog_keyed_top i_wdog_keyed_top (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_addr_i(addr),
    .bus_we_i(we), .bus_re_i(re), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .rst_req_o(rst_req)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: read data one cycle after strobe (R10), pulse counter
  always @(posedge clk) rd_flag <= re;
  always @(negedge clk) begin
    if (rst_req) pulses++;
    if (rd_flag) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected read", rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata == e, t, rdata, e);
      end
    end
  end

  task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                     input logic [31:0] d, input logic tk);
    @(negedge clk);
    we = w; re = r; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    we = 1'b0; re = 1'b0; addr = '0; wdata = '0; tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    cyc(1'b0, 1'b1, a, '0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, '0, 1'b1);
  endtask

  task automatic exp_pulses(input int n, input string tag);
    #1;
    chk(pulses == n, tag, pulses, n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rst_req == 1'b0, "R1 rst_req after reset", rst_req, 0);
    rd(8'h04, 32'h0000_0FFF, "R1 restart reset value");
    rd(8'h08, 32'h0000_7FFF, "R1 mode reset value");
    rd(8'h0C, 32'h0, "R1 status reset value");
    // R7: width of stored fields
    wr(8'h04, 32'hFFFF_F005);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0000_0005, "R7 restart field");
    rd(8'h08, 32'h0000_7FFF, "R7 mode field");
    // R6: placeholders and unmapped read zero
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R6 protection slot");
    rd(8'h18, 32'h0, "R6 clock-select slot");
    rd(8'h00, 32'h0, "R6 control reads zero");
    rd(8'h3C, 32'h0, "R6 unmapped");
    // R4 keyed restart, then R2 hold and count
    wr(8'h00, 32'h5FA0_0001);
    repeat (20) cyc(1'b0, 1'b0, '0, '0, 1'b0);
    exp_pulses(0, "R7 restart write did not reload / R2 hold");
    ticks(5); exp_pulses(0, "R2 five ticks from 5");
    ticks(1); exp_pulses(1, "R3 expiry on sixth tick");
    rd(8'h0C, 32'h1, "R3 status set");
    rd(8'h0C, 32'h0, "R8 status cleared by read");
    // R3 automatic reload
    ticks(5); exp_pulses(1, "R3 reload period");
    ticks(1); exp_pulses(2, "R3 second expiry");
    // R5 wrong key
    ticks(3);
    wr(8'h00, 32'h5FA1_0001);
    ticks(2); exp_pulses(2, "R5 bad key");
    ticks(1); exp_pulses(3, "R5 bad key ignored");
    // R5 right key, bit0 clear
    ticks(3);
    wr(8'h00, 32'h5FA0_0000);
    ticks(2); exp_pulses(3, "R5 bit0 clear");
    ticks(1); exp_pulses(4, "R5 bit0 clear ignored");
    // R4 restart mid count
    ticks(3);
    wr(8'h00, 32'h5FA0_0001);
    ticks(5); exp_pulses(4, "R4 restart mid count");
    ticks(1); exp_pulses(5, "R4 expiry after restart");
    // R9 collision
    rd(8'h0C, 32'h1, "R3 status before collision");
    ticks(5);
    cyc(1'b1, 1'b0, 8'h00, 32'h5FA0_0001, 1'b1);
    exp_pulses(5, "R9 no request on collision");
    rd(8'h0C, 32'h0, "R9 no status on collision");
    ticks(5); exp_pulses(5, "R9 restart value taken");
    ticks(1); exp_pulses(6, "R9 expiry after collision");
    // R8 read coinciding with expiry
    rd(8'h0C, 32'h1, "R8 status read");
    ticks(5);
    exp_q.push_back(32'h0); tag_q.push_back("R8 read during expiry");
    cyc(1'b0, 1'b1, 8'h0C, '0, 1'b1);
    exp_pulses(7, "R8 expiry with read");
    rd(8'h0C, 32'h1, "R8 set wins over clear");
    rd(8'h0C, 32'h0, "R8 cleared afterwards");
    // R3 boundary: restart value 0
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h5FA0_0001);
    ticks(1); exp_pulses(8, "R3 zero restart first");
    ticks(1); exp_pulses(9, "R3 zero restart every tick");
    rd(8'h04, 32'h0, "R7 restart zero readback");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired R10 actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule